// File: doc/BRIEF.md
# Control Endpoint Status and Buffer

This block holds the status side of a device's bidirectional control endpoint (endpoint 0). A single 32-byte store carries either a received OUT packet or an IN packet that software has staged. It never carries both at once, and it has no second bank. A simplified packet engine reports finished events: a byte received, a packet received, an IN packet sent, a status stage completed, a stall sent, and a control transfer cut short. Software sees a small register window with handshake flags, a byte count, a data port and the device address.

Software drains a received packet through the data port and then releases the store. To send, it fills the store through the same port and sets the IN-ready flag. The engine pulls bytes out and reports when the packet has gone, and the hardware then clears the flag. Every relevant event produces a one-cycle event pulse. The device address also gates access to endpoints other than zero.

Top module: `ctl_ep_status`

## Requirements
- R1: After reset, all flags, the byte count, the device address and `ep0_irq` are zero.
- R2: The OUT-ready and IN-ready flags are never both set. While either flag is set, received bytes and `pe_rx_done` are ignored. A request to set IN-ready is ignored while either flag is set, and also when an accepted `pe_rx_done` arrives in the same cycle.
- R3: Received bytes are stored in order. An accepted `pe_rx_done` sets OUT-ready, which is bit 0 of the control register at address 0. The count register at address 1 reports the number of stored bytes.
- R4: Received bytes beyond 32 are dropped, the count stays at 32, and the overflow flag (control bit 4) is set.
- R5: While OUT-ready is set, each read of the data port (address 2) returns the next stored byte and then advances. Once all stored bytes have been read, the data port returns 0 and does not advance. In every other state the data port reads 0.
- R6: Writing 1 to control bit 0 while OUT-ready is set clears OUT-ready, the overflow flag, the count and the read position.
- R7: While both ready flags are clear, writes to the data port append bytes, up to 32; extra bytes are dropped. Writing 1 to control bit 1 sets IN-ready (control read bit 1). While IN-ready is set, `pe_tx_byte` shows the next byte and `pe_tx_rd` advances it. `pe_tx_done` clears IN-ready and the count.
- R8: `pe_stall_sent` sets the stall flag (control bit 2), and `pe_setup_abort` sets the setup-end flag (control bit 3). Writing 1 to control bit 6 clears the stall flag, and writing 1 to control bit 7 clears the setup-end flag. A hardware set in the same cycle as a clear wins.
- R9: `ep0_irq` goes high for exactly the cycle after any of these events: an accepted `pe_rx_done`, `pe_tx_done` while IN-ready is set, `pe_status_done`, `pe_stall_sent`, or `pe_setup_abort`. It stays low after an ignored `pe_rx_done` or `pe_tx_done`.
- R10: The address register (address 3) keeps write bits 6:0. `ep_allow` is high when `pe_ep_num` is 0 or the address is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data port) |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 data, 3 address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| pe_rx_valid | input | 1 | Received byte strobe |
| pe_rx_byte | input | 8 | Received byte |
| pe_rx_done | input | 1 | OUT data packet complete |
| pe_tx_rd | input | 1 | Engine consumes one IN byte |
| pe_tx_byte | output | 8 | Next IN byte, 0 when none |
| pe_tx_done | input | 1 | IN packet delivered to the host |
| pe_status_done | input | 1 | Status stage completed |
| pe_stall_sent | input | 1 | Stall handshake sent |
| pe_setup_abort | input | 1 | Control transfer ended early |
| pe_ep_num | input | 4 | Endpoint number of the current token |
| ep_allow | output | 1 | Endpoint may be accessed |
| ep0_irq | output | 1 | One-cycle endpoint-0 event pulse |

## Verification
The hardest cases to reach are same-cycle collisions. One is a packet-complete report arriving in the same cycle as software's request to set IN-ready. The others are a stall or setup-end report arriving in the same cycle as software's clear of the same flag. The stimulus drives these pairs together in one cycle and then reads the control register to see which side won. Overflow needs a packet of more than 32 bytes, followed by a drain that shows exactly the first 32 bytes in order.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_ADDR  = 2'd3
    } reg_sel_e;

    // control register bit positions (read side)
    localparam int unsigned CB_OUT   = 0;
    localparam int unsigned CB_IN    = 1;
    localparam int unsigned CB_STALL = 2;
    localparam int unsigned CB_SETUP = 3;
    localparam int unsigned CB_OVF   = 4;
    // control register bit positions (write-one service side)
    localparam int unsigned CB_CLR_STALL = 6;
    localparam int unsigned CB_CLR_SETUP = 7;

    localparam int unsigned EV_COUNT = 5;
endpackage

// File: rtl/ctl_ep_buf.sv
module ctl_ep_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/ctl_ep_evt.sv
module ctl_ep_evt #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    output logic         irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = |ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
    import ctl_ep_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 7,
    parameter int EPN_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             pe_rx_valid,
    input  logic [7:0]       pe_rx_byte,
    input  logic             pe_rx_done,
    input  logic             pe_tx_rd,
    output logic [7:0]       pe_tx_byte,
    input  logic             pe_tx_done,
    input  logic             pe_status_done,
    input  logic             pe_stall_sent,
    input  logic             pe_setup_abort,
    input  logic [EPN_W-1:0] pe_ep_num,
    output logic             ep_allow,
    output logic             ep0_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic              out_rdy;
        logic              in_rdy;
        logic              stall;
        logic              setup;
        logic              ovf;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  ptr;
        logic [ADDR_W-1:0] addr;
    } ep_state_t;

    ep_state_t st_d, st_q;

    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;
    logic [7:0]       buf_wdata;
    logic [7:0]       buf_rdata;

    logic busy, room, have_byte;
    logic wr_ctrl, wr_data, wr_addr, rd_data;
    logic rx_take, sw_push, rx_acc, tx_fin, set_in;
    logic [EV_COUNT-1:0] ev_vec;

    assign busy      = st_q.out_rdy | st_q.in_rdy;
    assign room      = st_q.cnt < FULL;
    assign have_byte = st_q.ptr < st_q.cnt;

    assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
    assign wr_data = reg_wr && (reg_addr == SEL_DATA);
    assign wr_addr = reg_wr && (reg_addr == SEL_ADDR);
    assign rd_data = reg_rd && (reg_addr == SEL_DATA);

    assign rx_take = pe_rx_valid && !busy;
    assign sw_push = wr_data && !busy && !pe_rx_valid;
    assign rx_acc  = pe_rx_done && !busy;
    assign tx_fin  = pe_tx_done && st_q.in_rdy;
    assign set_in  = wr_ctrl && reg_wdata[CB_IN] && !busy && !rx_acc;

    // next-state computation
    always_comb begin
        st_d      = st_q;
        buf_we    = 1'b0;
        buf_widx  = st_q.cnt[IDX_W-1:0];
        buf_wdata = pe_rx_byte;

        // buffer fill: engine bytes take the single write port first
        if (rx_take) begin
            if (room) begin
                buf_we   = 1'b1;
                st_d.cnt = st_q.cnt + ONE;
            end else begin
                st_d.ovf = 1'b1;
            end
        end else if (sw_push && room) begin
            buf_we    = 1'b1;
            buf_wdata = reg_wdata;
            st_d.cnt  = st_q.cnt + ONE;
        end

        if (rx_acc) begin
            st_d.out_rdy = 1'b1;
        end

        if (set_in) begin
            st_d.in_rdy = 1'b1;
            st_d.ptr    = '0;
        end

        // software releases a received packet
        if (wr_ctrl && reg_wdata[CB_OUT] && st_q.out_rdy) begin
            st_d.out_rdy = 1'b0;
            st_d.ovf     = 1'b0;
            st_d.cnt     = '0;
            st_d.ptr     = '0;
        end

        if (pe_tx_rd && st_q.in_rdy && have_byte) begin
            st_d.ptr = st_q.ptr + ONE;
        end

        if (rd_data && st_q.out_rdy && have_byte) begin
            st_d.ptr = st_q.ptr + ONE;
        end

        if (tx_fin) begin
            st_d.in_rdy = 1'b0;
            st_d.cnt    = '0;
            st_d.ptr    = '0;
        end

        // sticky flags: hardware set overrides a same-cycle clear
        if (wr_ctrl && reg_wdata[CB_CLR_STALL]) st_d.stall = 1'b0;
        if (pe_stall_sent)                      st_d.stall = 1'b1;
        if (wr_ctrl && reg_wdata[CB_CLR_SETUP]) st_d.setup = 1'b0;
        if (pe_setup_abort)                     st_d.setup = 1'b1;

        if (wr_addr) begin
            st_d.addr = reg_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ctl_ep_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (buf_wdata),
        .ridx  (st_q.ptr[IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    assign ev_vec = {rx_acc, tx_fin, pe_status_done, pe_stall_sent, pe_setup_abort};

    ctl_ep_evt #(.N(EV_COUNT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec),
        .irq   (ep0_irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_CTRL:  reg_rdata = {3'b000, st_q.ovf, st_q.setup, st_q.stall,
                                    st_q.in_rdy, st_q.out_rdy};
            SEL_COUNT: reg_rdata = 8'(st_q.cnt);
            SEL_DATA:  reg_rdata = (st_q.out_rdy && have_byte) ? buf_rdata : 8'h00;
            SEL_ADDR:  reg_rdata = 8'(st_q.addr);
            default:   reg_rdata = '0;
        endcase
    end

    assign pe_tx_byte = (st_q.in_rdy && have_byte) ? buf_rdata : 8'h00;
    assign ep_allow   = (pe_ep_num == '0) || (st_q.addr != '0);

    // plain views of state for the bound checker
    logic             mon_out, mon_in, mon_stall, mon_addr_zero;
    logic [CNT_W-1:0] mon_cnt;
    assign mon_out       = st_q.out_rdy;
    assign mon_in        = st_q.in_rdy;
    assign mon_stall     = st_q.stall;
    assign mon_cnt       = st_q.cnt;
    assign mon_addr_zero = (st_q.addr == '0);
endmodule

// File: rtl/ctl_ep_status_chk.sv
module ctl_ep_status_chk #(
    parameter int DEPTH = 32,
    parameter int EPN_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_rdy,
    input logic             in_rdy,
    input logic             stall,
    input logic [CNT_W-1:0] cnt,
    input logic             addr_zero,
    input logic             pe_stall_sent,
    input logic             pe_status_done,
    input logic             pe_tx_done,
    input logic [EPN_W-1:0] pe_ep_num,
    input logic             ep_allow,
    input logic             ep0_irq
);
    // R2
    excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_rdy && in_rdy));

    // R4
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R8
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_stall_sent |=> stall);

    // R9
    status_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_status_done |=> ep0_irq);

    // R7
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && pe_tx_done) |=> (!in_rdy && cnt == '0));

    // R10
    allow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_ep_num != '0 && addr_zero) |-> !ep_allow);
endmodule

bind ctl_ep_status ctl_ep_status_chk #(.DEPTH(DEPTH), .EPN_W(EPN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .out_rdy        (mon_out),
    .in_rdy         (mon_in),
    .stall          (mon_stall),
    .cnt            (mon_cnt),
    .addr_zero      (mon_addr_zero),
    .pe_stall_sent  (pe_stall_sent),
    .pe_status_done (pe_status_done),
    .pe_tx_done     (pe_tx_done),
    .pe_ep_num      (pe_ep_num),
    .ep_allow       (ep_allow),
    .ep0_irq        (ep0_irq)
);

// File: tb/sim_ctl_ep_status.sv
module sim_ctl_ep_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pe_rx_valid = 1'b0;
    logic [7:0] pe_rx_byte = 8'h00;
    logic       pe_rx_done = 1'b0, pe_tx_rd = 1'b0, pe_tx_done = 1'b0;
    logic [7:0] pe_tx_byte;
    logic       pe_status_done = 1'b0, pe_stall_sent = 1'b0, pe_setup_abort = 1'b0;
    logic [3:0] pe_ep_num = 4'd0;
    logic       ep_allow, ep0_irq;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ctl_ep_status u0 (.*);

    // reference model state
    bit         m_out = 0, m_in = 0, m_stall = 0, m_setup = 0, m_ovf = 0, m_irq = 0;
    logic [6:0] m_addr = 7'd0;
    logic [7:0] q[$];
    int         rp = 0;
    bit         o_out, o_in, busy, ev;
    int         o_rp, o_size;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_in = 0; m_stall = 0; m_setup = 0; m_ovf = 0; m_irq = 0;
            m_addr = 7'd0; q.delete(); rp = 0;
        end else begin
            o_out = m_out; o_in = m_in; o_rp = rp; o_size = q.size();
            busy = o_out || o_in; ev = 0;
            if (pe_rx_valid && !busy) begin
                if (o_size < 32) q.push_back(pe_rx_byte); else m_ovf = 1;
            end else if (reg_wr && reg_addr == 2'd2 && !busy && o_size < 32)
                q.push_back(reg_wdata);
            if (pe_rx_done && !busy) begin m_out = 1; ev = 1; end
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[1] && !busy && !pe_rx_done) begin
                m_in = 1; rp = 0;
            end
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[0] && o_out) begin
                m_out = 0; m_ovf = 0; q.delete(); rp = 0;
            end
            if (pe_tx_rd && o_in && o_rp < o_size) rp = o_rp + 1;
            if (reg_rd && reg_addr == 2'd2 && o_out && o_rp < o_size) rp = o_rp + 1;
            if (pe_tx_done && o_in) begin m_in = 0; q.delete(); rp = 0; ev = 1; end
            if (pe_status_done) ev = 1;
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[6]) m_stall = 0;
            if (pe_stall_sent) begin m_stall = 1; ev = 1; end
            if (reg_wr && reg_addr == 2'd0 && reg_wdata[7]) m_setup = 0;
            if (pe_setup_abort) begin m_setup = 1; ev = 1; end
            if (reg_wr && reg_addr == 2'd3) m_addr = reg_wdata[6:0];
            m_irq = ev;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            2'd0: return {3'b000, m_ovf, m_setup, m_stall, m_in, m_out};
            2'd1: return 8'(q.size());
            2'd2: return (m_out && rp < q.size()) ? q[rp] : 8'h00;
            default: return {1'b0, m_addr};
        endcase
    endfunction

    // compare away from the clock edge, after new inputs settle
    always @(negedge clk) begin
        #2;
        if (!done) begin
            logic [7:0] e_rd, e_tx;
            logic       e_allow;
            e_rd    = exp_rdata();
            e_tx    = (m_in && rp < q.size()) ? q[rp] : 8'h00;
            e_allow = (pe_ep_num == 4'd0) || (m_addr != 7'd0);
            vectors++;
            if (reg_rdata !== e_rd) begin
                fails++;
                $display("FAIL %s reg_rdata[a=%0d] actual %0h expected %0h", cur_req, reg_addr, reg_rdata, e_rd);
            end
            if (pe_tx_byte !== e_tx) begin
                fails++;
                $display("FAIL %s pe_tx_byte actual %0h expected %0h", cur_req, pe_tx_byte, e_tx);
            end
            if (ep0_irq !== m_irq) begin
                fails++;
                $display("FAIL %s ep0_irq actual %0b expected %0b", cur_req, ep0_irq, m_irq);
            end
            if (ep_allow !== e_allow) begin
                fails++;
                $display("FAIL %s ep_allow actual %0b expected %0b", cur_req, ep_allow, e_allow);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; pe_rx_valid = 0; pe_rx_done = 0; pe_tx_rd = 0;
        pe_tx_done = 0; pe_status_done = 0; pe_stall_sent = 0; pe_setup_abort = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; step();
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a; reg_rd = 1; step();
    endtask

    task automatic peek(input logic [1:0] a);
        reg_addr = a; step();
    endtask

    task automatic rx_pkt(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            pe_rx_valid = 1; pe_rx_byte = base + 8'(i); step();
        end
        pe_rx_done = 1; step();
        peek(0); peek(1);
    endtask

    initial begin
        step(); step(); step();
        rst_n = 1;
        cur_req = "R1";
        for (int a = 0; a < 4; a++) peek(2'(a));

        cur_req = "R3"; rx_pkt(5, 8'h10);
        cur_req = "R5";
        for (int i = 0; i < 7; i++) rd(2);
        cur_req = "R6"; wr(0, 8'h01); peek(0); peek(1); peek(2);

        cur_req = "R4"; rx_pkt(35, 8'h40);
        for (int i = 0; i < 33; i++) rd(2);
        wr(0, 8'h01); peek(0);

        cur_req = "R2"; rx_pkt(2, 8'hA0);
        for (int i = 0; i < 3; i++) begin pe_rx_valid = 1; pe_rx_byte = 8'hEE; step(); end
        pe_rx_done = 1; step(); peek(1);
        wr(0, 8'h02); peek(0);
        wr(2, 8'h55); peek(1);
        wr(0, 8'h01);
        reg_addr = 0; reg_wdata = 8'h02; reg_wr = 1; pe_rx_done = 1; step();
        peek(0); wr(0, 8'h01); peek(0);

        cur_req = "R7";
        for (int i = 0; i < 4; i++) wr(2, 8'hC0 + 8'(i));
        peek(1); wr(0, 8'h02); peek(0); peek(2);
        wr(2, 8'h99); peek(1);
        for (int i = 0; i < 5; i++) begin pe_tx_rd = 1; step(); end
        pe_tx_done = 1; step(); peek(0); peek(1);
        for (int i = 0; i < 34; i++) wr(2, 8'(i * 3));
        peek(1); wr(0, 8'h02);
        for (int i = 0; i < 33; i++) begin pe_tx_rd = 1; step(); end
        pe_tx_done = 1; step(); peek(0);

        cur_req = "R9";
        pe_tx_done = 1; step(); step();
        pe_rx_done = 1; step(); step(); peek(0);
        wr(0, 8'h01);
        pe_status_done = 1; step(); step();

        cur_req = "R8";
        pe_stall_sent = 1; step(); peek(0);
        wr(0, 8'h40); peek(0);
        pe_setup_abort = 1; step(); peek(0);
        wr(0, 8'h80); peek(0);
        reg_addr = 0; reg_wdata = 8'hC0; reg_wr = 1; pe_stall_sent = 1; pe_setup_abort = 1; step();
        peek(0); wr(0, 8'hC0); peek(0);

        cur_req = "R10";
        for (int e = 0; e < 16; e++) begin pe_ep_num = 4'(e); peek(3); end
        wr(3, 8'hC5); peek(3);
        for (int e = 0; e < 16; e++) begin pe_ep_num = 4'(e); peek(3); end
        wr(3, 8'h80); peek(3); pe_ep_num = 4'd9; peek(3);

        cur_req = "R1";
        rst_n = 0; step(); step(); rst_n = 1;
        for (int a = 0; a < 4; a++) peek(2'(a));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule